// File: doc/BRIEF.md
# Closed Caption Status Register

This block is the read-only status byte of a video encoder's serial control port. The byte carries three things: a fixed device version, one "caption done" flag for each field parity, and the current value of the encoder's three-bit field sequence counter. Software writes caption bytes for the odd field at subaddresses 67h and 68h. It writes caption bytes for the even field at 69h and 6Ah. The matching flag then drops. The flag rises again only when the encoder reports that it has inserted the caption data into a field of that parity. By polling this byte, software knows when it may load the next caption pair.

The serial protocol engine sits outside this block. It gives the block a one-cycle read-start strobe together with the read address it has decoded. When that address is one of the two read addresses (89h or 8Dh), the block takes a snapshot of the byte. The snapshot holds still while the engine shifts it out. The block also sees the engine's register write strobe and subaddress, the per-field encode pulses from the caption modulator, and the field sequence count.

Top module: `cc_status_reg`

## Requirements
- R1: The read byte places the version in bits 7:5, the odd-field done flag in bit 4, the even-field done flag in bit 3 and the field sequence count in bits 2:0.
- R2: The version field always reads binary 100.
- R3: After reset both done flags are 1 and the read byte is 98h (version 100, both flags set, sequence 000).
- R4: A write to subaddress 67h or 68h clears the odd-field flag at the next edge, and further odd writes keep it cleared.
- R5: A write to subaddress 69h or 6Ah clears the even-field flag at the next edge, and further even writes keep it cleared.
- R6: An encode pulse for a field sets that field's flag at the next edge. A pulse for one parity leaves the other flag unchanged.
- R7: When a write to a field's subaddress and that field's encode pulse arrive in the same cycle, the flag ends up cleared.
- R8: A read-start strobe with read address 89h or 8Dh captures the byte at that edge, using the flag values from before that edge and the current sequence count. A read-start strobe with any other address is ignored.
- R9: The captured byte stays unchanged until the next accepted read-start, whatever the flags and the sequence count do.
- R10: Writes to subaddresses other than 67h, 68h, 69h and 6Ah have no effect on either flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe from the serial engine |
| wr_sub | input | 8 | Subaddress of the write |
| enc_odd | input | 1 | Odd-field caption encoded pulse |
| enc_even | input | 1 | Even-field caption encoded pulse |
| fseq | input | 3 | Field sequence counter value |
| rd_start | input | 1 | Start of a slave read, one cycle |
| rd_addr | input | 8 | Read address decoded by the serial engine |
| rd_byte | output | 8 | Captured status byte |

## Verification
A vector walk applies one operation per step and then reads the byte. The operations are a single odd or even write, encode pulses, a write coinciding with a pulse, and a write to an unrelated subaddress. The field sequence value changes on every step, so a swapped or misplaced bit field shows up as a wrong byte. Directed tests separate the two accepted read addresses from a rejected one, check that the snapshot holds while the flags and the sequence count change, and check that a read arriving in the same cycle as a write returns the flag as it was before the write.

// File: rtl/cc_status_reg.sv
module cc_status_reg #(
  parameter logic [2:0] VERSION  = 3'b100,
  parameter logic [7:0] SUB_ODD0 = 8'h67,
  parameter logic [7:0] SUB_ODD1 = 8'h68,
  parameter logic [7:0] SUB_EVN0 = 8'h69,
  parameter logic [7:0] SUB_EVN1 = 8'h6A,
  parameter logic [7:0] RD_ADR0  = 8'h89,
  parameter logic [7:0] RD_ADR1  = 8'h8D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_sub,
  input  logic       enc_odd,
  input  logic       enc_even,
  input  logic [2:0] fseq,
  input  logic       rd_start,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_byte
);
  logic odd_done, even_done;
  logic wr_odd, wr_even, rd_hit;
  logic [7:0] live_byte;

  assign wr_odd    = wr_en && (wr_sub == SUB_ODD0 || wr_sub == SUB_ODD1);
  assign wr_even   = wr_en && (wr_sub == SUB_EVN0 || wr_sub == SUB_EVN1);
  assign rd_hit    = rd_start && (rd_addr == RD_ADR0 || rd_addr == RD_ADR1);
  assign live_byte = {VERSION, odd_done, even_done, fseq};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odd_done  <= 1'b1;
      even_done <= 1'b1;
      rd_byte   <= {VERSION, 2'b11, 3'b000};
    end else begin
      if (wr_odd)        odd_done  <= 1'b0;
      else if (enc_odd)  odd_done  <= 1'b1;
      if (wr_even)       even_done <= 1'b0;
      else if (enc_even) even_done <= 1'b1;
      if (rd_hit)        rd_byte   <= live_byte;
    end
  end
endmodule

module cc_status_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_sub,
  input logic       enc_odd,
  input logic       enc_even,
  input logic [2:0] fseq,
  input logic       rd_start,
  input logic [7:0] rd_addr,
  input logic [7:0] rd_byte,
  input logic       odd_done,
  input logic       even_done
);
  logic odd_w, even_w, hit;
  assign odd_w  = wr_en && (wr_sub == 8'h67 || wr_sub == 8'h68);
  assign even_w = wr_en && (wr_sub == 8'h69 || wr_sub == 8'h6A);
  assign hit    = rd_start && (rd_addr == 8'h89 || rd_addr == 8'h8D);

  // R4 R7
  odd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    odd_w |=> !odd_done);
  // R5 R7
  even_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    even_w |=> !even_done);
  // R6
  odd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_odd && !odd_w) |=> odd_done);
  // R6
  even_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_even && !even_w) |=> even_done);
  // R8 R1
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> rd_byte == {3'b100, $past(odd_done), $past(even_done), $past(fseq)});
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(rd_byte));
  // R10
  odd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!odd_w && !enc_odd) |=> $stable(odd_done));
endmodule

bind cc_status_reg cc_status_reg_chk u_chk (.*);

// File: tb/cc_status_reg_tb.sv
module cc_status_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {wr_en, wr_sub[7:0], enc_odd, enc_even, fseq[2:0], expected byte[7:0]}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 8'h98},  // R3 R1 idle
    {1'b1, 8'h67, 1'b0, 1'b0, 3'd1, 8'h89},  // R4
    {1'b1, 8'h6A, 1'b0, 1'b0, 3'd2, 8'h82},  // R5
    {1'b0, 8'h00, 1'b1, 1'b0, 3'd3, 8'h93},  // R6 odd only
    {1'b1, 8'h68, 1'b1, 1'b0, 3'd4, 8'h84},  // R7 R4
    {1'b0, 8'h00, 1'b0, 1'b1, 3'd5, 8'h8D},  // R6 even only
    {1'b1, 8'h55, 1'b0, 1'b0, 3'd6, 8'h8E},  // R10
    {1'b0, 8'h00, 1'b1, 1'b0, 3'd7, 8'h9F},  // R6 R2
    {1'b1, 8'h69, 1'b0, 1'b1, 3'd0, 8'h90},  // R7 R5
    {1'b0, 8'h00, 1'b1, 1'b0, 3'd1, 8'h91}   // R6 already set
  };

  logic clk = 0, rst_n = 0, wr_en = 0, enc_odd = 0, enc_even = 0, rd_start = 0;
  logic [7:0] wr_sub = 0, rd_addr = 0, rd_byte;
  logic [2:0] fseq = 0;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_status_reg u_dut (.*);

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (rd_byte !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, rd_byte, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] s, input logic eo, input logic ee,
                      input logic [2:0] f, input logic r, input logic [7:0] ra);
    wr_en = w; wr_sub = s; enc_odd = eo; enc_even = ee; fseq = f;
    rd_start = r; rd_addr = ra;
    @(negedge clk);
    wr_en = 0; enc_odd = 0; enc_even = 0; rd_start = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R3", 8'h98);
    rst_n = 1;
    @(negedge clk);
    check("R3", 8'h98);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][21], VEC[i][20:13], VEC[i][12], VEC[i][11], VEC[i][10:8], 1'b0, 8'h00);
      step(1'b0, 8'h00, 1'b0, 1'b0, VEC[i][10:8], 1'b1, 8'h89);
      check($sformatf("R1/R4-R7/R10 vector %0d", i), VEC[i][7:0]);
    end
    // flags now odd=1 even=0, byte 91h

    // R8 other read address ignored
    step(1'b0, 8'h00, 1'b0, 1'b0, 3'd6, 1'b1, 8'h88);
    check("R8 rejected address", 8'h91);
    // R8 second read address accepted
    step(1'b0, 8'h00, 1'b0, 1'b0, 3'd6, 1'b1, 8'h8D);
    check("R8 address 8Dh", 8'h96);
    // R9 hold while flags and fseq change
    step(1'b0, 8'h00, 1'b0, 1'b1, 3'd2, 1'b0, 8'h00);
    step(1'b1, 8'h67, 1'b0, 1'b0, 3'd3, 1'b0, 8'h00);
    check("R9 hold", 8'h96);
    // flags odd=0 even=1; R8 read in same cycle as even write sees pre-write flag
    step(1'b1, 8'h69, 1'b0, 1'b0, 3'd4, 1'b1, 8'h89);
    check("R8 pre-write capture", 8'h8C);
    step(1'b0, 8'h00, 1'b0, 1'b0, 3'd4, 1'b1, 8'h89);
    check("R5 after write", 8'h84);
    // R4 repeated odd write keeps cleared, then one pulse sets
    step(1'b1, 8'h68, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00);
    step(1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1, 8'h8D);
    check("R4 repeat write", 8'h80);
    step(1'b0, 8'h00, 1'b1, 1'b1, 3'd7, 1'b0, 8'h00);
    step(1'b0, 8'h00, 1'b0, 1'b0, 3'd7, 1'b1, 8'h89);
    check("R6 both pulses", 8'h9F);
    // R3 reset again
    rst_n = 0;
    @(negedge clk);
    check("R3 re-reset", 8'h98);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule